// File: doc/BRIEF.md
# Per-port memory-mapped configuration decoder

This block gives a multi-port switch one memory-mapped region that holds the configuration registers of every port. Software first gives the region a base by writing the upstream port's 64-bit base address pair through the configuration path. It then turns on memory decoding through the upstream command register. After that, every port's registers can be read and written with ordinary DWord memory requests. The region is 128 KB long. Address bits [16:12] pick a 4 KB port window, and bits [11:2] pick the register inside that window.

Each write to the upstream base pair is also copied, in the same clock, into a shadow pair. Stations of eight ports each hold these shadow pairs. The shadows sit in port 0 for upstream ports 0 to 7, and in port 8 for upstream ports 8 to 15. A shadow can be rewritten later without touching the base, so each station can carry its own memory window. Behind the decoder sits a small model of the per-port register files: a command bit, the base pair, a few scratch DWords per port, and the shadow arrays.

Top module: `mmcfg_window_decoder`

## Requirements
- R1: After reset, rsp_valid is low. The base pair, the memory-enable bit, the scratch registers and the shadow registers all read as zero.
- R2: A configuration write to offset 010h or 014h of the upstream port sets the low or high DWord of the base. Bits [16:0] of the low DWord always read as zero.
- R3: A memory request reaches a port only when the memory-enable bit is set and address bits [63:17] equal the base bits [63:17]. Any other memory read returns zero, and any other memory write is dropped.
- R4: Address bits [16:12] select the port window, and bits [11:2] select the DWord register. Scratch DWords at offsets 040h to 04Ch are separate in every port.
- R5: Windows of inactive ports (parameter mask), and windows 16 to 31, read as zero and ignore writes.
- R6: A write to the upstream base pair is copied, in the same clock, to the shadow pair at offset 6C0h + 8×(u mod 8). The low DWord goes first. The copy lands in port 0 when upstream port u is 0 to 7, and in port 8 when u is 8 to 15. The other station's shadows stay unchanged.
- R7: A write to a shadow register changes only that shadow and never the base.
- R8: Byte enable bit i selects whether write-data byte i updates the target. This holds for the base pair, the copies to the shadow pair and the scratch registers.
- R9: Every read request gives exactly one cycle of rsp_valid on the next clock, with the data. Writes give none, and rsp_rdata is zero while rsp_valid is low.
- R10: The upstream command register at offset 004h holds only the memory-enable bit at bit 1. All of its other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upstream_port | input | 4 | Number of the port that acts as upstream |
| req_valid | input | 1 | Request present this cycle |
| req_cfg | input | 1 | 1: configuration access to the upstream port; 0: memory access to the region |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | 62 | DWord address, bits [63:2] |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest behaviour to reach is the copy from a base write into a shadow pair. It is only visible once the region decodes, and it depends on which station the upstream port belongs to. The stimulus first programs and enables the base through the configuration path. It then reads the copy back through memory windows 0 and 8. Next it overwrites a shadow and checks that the base and the decoding still hold. Finally it switches the upstream port into the second station, rewrites the base, and confirms that only port 8's shadow pair changes. A partial byte-enable write moves the base itself, and reads then check that the old region misses and the new one hits.

// File: rtl/mmcfg_pkg.sv
package mmcfg_pkg;

    localparam int ADDR_W       = 64;
    localparam int WIN_LSB      = 12;
    localparam int REGION_LSB   = 17;
    localparam int WIN_W        = REGION_LSB - WIN_LSB;
    localparam int REG_IDX_W    = WIN_LSB - 2;
    localparam int STATION_SPAN = 8;
    localparam int SPAN_W       = $clog2(STATION_SPAN);
    localparam int SHADOW_W     = SPAN_W + 1;

    localparam logic [REG_IDX_W-1:0] IDX_CMD     = 10'h001;
    localparam logic [REG_IDX_W-1:0] IDX_BAR_LO  = 10'h004;
    localparam logic [REG_IDX_W-1:0] IDX_BAR_HI  = 10'h005;
    localparam logic [REG_IDX_W-1:0] IDX_SCRATCH = 10'h010;
    localparam logic [REG_IDX_W-1:0] IDX_SHADOW  = 10'h1B0;

    localparam logic [31:0] BAR_LO_MASK = 32'hFFFE_0000;

    typedef struct packed {
        logic                 hit;
        logic                 write;
        logic [WIN_W-1:0]     port;
        logic [REG_IDX_W-1:0] idx;
        logic [3:0]           be;
        logic [31:0]          wdata;
    } mmcfg_acc_t;

    function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
        logic [31:0] res;
        for (int b = 0; b < 4; b++) begin
            res[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/mmcfg_region_decode.sv
module mmcfg_region_decode
    import mmcfg_pkg::*;
#(
    parameter int                   NUM_PORTS   = 16,
    parameter logic [NUM_PORTS-1:0] PORT_ACTIVE = 16'h0F0F,
    parameter int                   UP_W        = $clog2(NUM_PORTS)
) (
    input  logic                         req_valid,
    input  logic                         req_cfg,
    input  logic                         req_write,
    input  logic [ADDR_W-1:2]            req_addr,
    input  logic [3:0]                   req_be,
    input  logic [31:0]                  req_wdata,
    input  logic [ADDR_W-1:REGION_LSB]   base_hi,
    input  logic                         mem_en,
    input  logic [UP_W-1:0]              up_port,
    output mmcfg_acc_t                   acc
);

    logic [WIN_W-1:0] win;
    logic             win_live;
    logic             in_region;

    always_comb begin
        win       = req_addr[REGION_LSB-1:WIN_LSB];
        win_live  = (int'(win) < NUM_PORTS) && PORT_ACTIVE[win[UP_W-1:0]];
        in_region = (req_addr[ADDR_W-1:REGION_LSB] == base_hi);

        acc.hit   = req_valid && (req_cfg || (mem_en && in_region && win_live));
        acc.write = req_write;
        acc.port  = req_cfg ? WIN_W'(up_port) : win;
        acc.idx   = req_addr[WIN_LSB-1:2];
        acc.be    = req_be;
        acc.wdata = req_wdata;
    end

endmodule

// File: rtl/mmcfg_port_regs.sv
module mmcfg_port_regs
    import mmcfg_pkg::*;
#(
    parameter int NUM_PORTS     = 16,
    parameter int SCRATCH_DEPTH = 4,
    parameter int UP_W          = $clog2(NUM_PORTS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  mmcfg_acc_t                   acc,
    input  logic [UP_W-1:0]              up_port,
    output logic [31:0]                  rd_data,
    output logic                         mem_en,
    output logic [ADDR_W-1:REGION_LSB]   base_hi
);

    localparam int SC_W     = $clog2(SCRATCH_DEPTH);
    localparam int STATIONS = NUM_PORTS / STATION_SPAN;
    localparam int ST_W     = UP_W - SPAN_W;
    localparam int SH_N     = 1 << SHADOW_W;

    logic                   mem_en_q;
    logic [31:REGION_LSB]   bar_lo_q;
    logic [31:0]            bar_hi_q;

    logic wr, is_up, in_scratch, in_shadow, sel_lo, sel_hi;
    logic [NUM_PORTS-1:0][31:0] scratch_rd;
    logic [STATIONS-1:0][31:0]  shadow_rd;

    always_comb begin
        wr         = acc.hit && acc.write;
        is_up      = (acc.port == WIN_W'(up_port));
        in_scratch = (acc.idx[REG_IDX_W-1:SC_W] == IDX_SCRATCH[REG_IDX_W-1:SC_W]);
        in_shadow  = (acc.idx[REG_IDX_W-1:SHADOW_W] == IDX_SHADOW[REG_IDX_W-1:SHADOW_W]);
        sel_lo     = is_up && (acc.idx == IDX_BAR_LO);
        sel_hi     = is_up && (acc.idx == IDX_BAR_HI);
    end

    // Upstream command bit and base pair
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_en_q <= 1'b0;
            bar_lo_q <= '0;
            bar_hi_q <= '0;
        end else if (wr) begin
            if (is_up && acc.idx == IDX_CMD && acc.be[0])
                mem_en_q <= acc.wdata[1];
            if (sel_lo) begin
                logic [31:0] nv;
                nv = be_merge({bar_lo_q, {REGION_LSB{1'b0}}}, acc.wdata, acc.be);
                bar_lo_q <= nv[31:REGION_LSB];
            end
            if (sel_hi)
                bar_hi_q <= be_merge(bar_hi_q, acc.wdata, acc.be);
        end
    end

    // Per-port scratch DWords
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [31:0] mem_q [SCRATCH_DEPTH];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SCRATCH_DEPTH; i++) mem_q[i] <= '0;
            end else if (wr && in_scratch && acc.port == WIN_W'(p)) begin
                mem_q[acc.idx[SC_W-1:0]] <= be_merge(mem_q[acc.idx[SC_W-1:0]], acc.wdata, acc.be);
            end
        end
        assign scratch_rd[p] = mem_q[acc.idx[SC_W-1:0]];
    end

    // Per-station shadow pairs, held in the first port of each station
    for (genvar s = 0; s < STATIONS; s++) begin : g_station
        logic [31:0]         sh_q [SH_N];
        logic                direct, copy;
        logic [SHADOW_W-1:0] copy_slot;
        logic [31:0]         copy_mask;

        always_comb begin
            direct    = wr && in_shadow && acc.port == WIN_W'(s * STATION_SPAN);
            copy      = wr && (sel_lo || sel_hi) && up_port[UP_W-1:SPAN_W] == ST_W'(s);
            copy_slot = {up_port[SPAN_W-1:0], sel_hi};
            copy_mask = sel_lo ? BAR_LO_MASK : '1;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SH_N; i++) sh_q[i] <= '0;
            end else if (direct) begin
                sh_q[acc.idx[SHADOW_W-1:0]] <= be_merge(sh_q[acc.idx[SHADOW_W-1:0]], acc.wdata, acc.be);
            end else if (copy) begin
                sh_q[copy_slot] <= be_merge(sh_q[copy_slot], acc.wdata & copy_mask, acc.be);
            end
        end
        assign shadow_rd[s] = sh_q[acc.idx[SHADOW_W-1:0]];
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        if (acc.hit) begin
            if (is_up && acc.idx == IDX_CMD) rd_data = {30'b0, mem_en_q, 1'b0};
            if (sel_lo)                      rd_data = {bar_lo_q, {REGION_LSB{1'b0}}};
            if (sel_hi)                      rd_data = bar_hi_q;
            if (in_scratch)                  rd_data = scratch_rd[acc.port[UP_W-1:0]];
            for (int s = 0; s < STATIONS; s++) begin
                if (in_shadow && acc.port == WIN_W'(s * STATION_SPAN)) rd_data = shadow_rd[s];
            end
        end
    end

    assign mem_en  = mem_en_q;
    assign base_hi = {bar_hi_q, bar_lo_q};

endmodule

// File: rtl/mmcfg_window_decoder.sv
module mmcfg_window_decoder
    import mmcfg_pkg::*;
#(
    parameter int                   NUM_PORTS     = 16,
    parameter logic [NUM_PORTS-1:0] PORT_ACTIVE   = 16'h0F0F,
    parameter int                   SCRATCH_DEPTH = 4,
    localparam int                  UP_W          = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UP_W-1:0]   upstream_port,
    input  logic              req_valid,
    input  logic              req_cfg,
    input  logic              req_write,
    input  logic [ADDR_W-1:2] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    mmcfg_acc_t                 acc;
    logic [31:0]                rd_data;
    logic                       mem_en;
    logic [ADDR_W-1:REGION_LSB] base_hi;

    mmcfg_region_decode #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_ACTIVE(PORT_ACTIVE),
        .UP_W       (UP_W)
    ) u_decode (
        .req_valid(req_valid),
        .req_cfg  (req_cfg),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_be   (req_be),
        .req_wdata(req_wdata),
        .base_hi  (base_hi),
        .mem_en   (mem_en),
        .up_port  (upstream_port),
        .acc      (acc)
    );

    mmcfg_port_regs #(
        .NUM_PORTS    (NUM_PORTS),
        .SCRATCH_DEPTH(SCRATCH_DEPTH),
        .UP_W         (UP_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .up_port(upstream_port),
        .rd_data(rd_data),
        .mem_en (mem_en),
        .base_hi(base_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
        end
    end

endmodule

// File: rtl/mmcfg_window_decoder_chk.sv
module mmcfg_window_decoder_chk
    import mmcfg_pkg::*;
#(
    parameter int NUM_PORTS = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_cfg,
    input logic                       req_write,
    input logic [ADDR_W-1:2]          req_addr,
    input logic                       rsp_valid,
    input logic [31:0]                rsp_rdata,
    input logic                       hit,
    input logic [ADDR_W-1:REGION_LSB] base_hi
);

    logic rd_req;
    assign rd_req = req_valid && !req_write;

    AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid); // R9
    AST_NO_RSP_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_valid); // R9
    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_rdata == 32'h0); // R9
    AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !hit) |=> rsp_rdata == 32'h0); // R3
    AST_DEAD_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !req_cfg && int'(req_addr[REGION_LSB-1:WIN_LSB]) >= NUM_PORTS) |=> rsp_rdata == 32'h0); // R5
    AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_cfg && req_addr[WIN_LSB-1:2] == IDX_BAR_LO) |=> rsp_rdata[REGION_LSB-1:0] == '0); // R2
    AST_CMD_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_cfg && req_addr[WIN_LSB-1:2] == IDX_CMD) |=> (rsp_rdata & ~32'h2) == 32'h0); // R10
    AST_BASE_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_addr[WIN_LSB-1:2] != IDX_BAR_LO
         && req_addr[WIN_LSB-1:2] != IDX_BAR_HI) |=> $stable(base_hi)); // R7

endmodule

bind mmcfg_window_decoder mmcfg_window_decoder_chk #(
    .NUM_PORTS(NUM_PORTS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_cfg  (req_cfg),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .hit      (acc.hit),
    .base_hi  (base_hi)
);

// File: tb/mmcfg_window_decoder_bench.sv
module mmcfg_window_decoder_bench;

    localparam logic [63:0] B  = 64'h0000_0012_3440_0000;
    localparam logic [63:0] B2 = 64'h0000_5612_3440_0000;

    typedef struct packed {
        logic        cfg;
        logic        wr;
        logic [63:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 64'h4,        4'hF, 32'h0,        32'h0,        4'd1},  // R1
        '{1'b1, 1'b0, 64'h10,       4'hF, 32'h0,        32'h0,        4'd1},  // R1
        '{1'b0, 1'b0, B + 64'h2040, 4'hF, 32'h0,        32'h0,        4'd3},  // R3 disabled
        '{1'b1, 1'b1, 64'h10,       4'hF, 32'h3441FFFF, 32'h0,        4'd2},  // R2
        '{1'b1, 1'b0, 64'h10,       4'hF, 32'h0,        32'h34400000, 4'd2},  // R2
        '{1'b1, 1'b1, 64'h14,       4'hF, 32'h12,       32'h0,        4'd2},  // R2
        '{1'b1, 1'b0, 64'h14,       4'hF, 32'h0,        32'h12,       4'd2},  // R2
        '{1'b0, 1'b0, B + 64'h40,   4'hF, 32'h0,        32'h0,        4'd3},  // R3 disabled
        '{1'b1, 1'b1, 64'h4,        4'hF, 32'hFFFFFFFF, 32'h0,        4'd10}, // R10
        '{1'b1, 1'b0, 64'h4,        4'hF, 32'h0,        32'h2,        4'd10}, // R10
        '{1'b0, 1'b1, B + 64'h40,   4'hF, 32'hA0A00001, 32'h0,        4'd4},  // R4
        '{1'b0, 1'b1, B + 64'h1044, 4'hF, 32'hB1B10002, 32'h0,        4'd4},  // R4
        '{1'b0, 1'b1, B + 64'h904C, 4'hF, 32'hC9C90003, 32'h0,        4'd4},  // R4
        '{1'b0, 1'b0, B + 64'h40,   4'hF, 32'h0,        32'hA0A00001, 4'd4},  // R4
        '{1'b0, 1'b0, B + 64'h1044, 4'hF, 32'h0,        32'hB1B10002, 4'd4},  // R4
        '{1'b0, 1'b0, B + 64'h904C, 4'hF, 32'h0,        32'hC9C90003, 4'd4},  // R4
        '{1'b0, 1'b0, B + 64'h1040, 4'hF, 32'h0,        32'h0,        4'd4},  // R4
        '{1'b0, 1'b1, B + 64'h4040, 4'hF, 32'hDEADBEEF, 32'h0,        4'd5},  // R5
        '{1'b0, 1'b0, B + 64'h4040, 4'hF, 32'h0,        32'h0,        4'd5},  // R5
        '{1'b0, 1'b0, B + 64'h12040,4'hF, 32'h0,        32'h0,        4'd5},  // R5
        '{1'b0, 1'b0, B + 64'h20040,4'hF, 32'h0,        32'h0,        4'd3},  // R3 outside
        '{1'b0, 1'b0, B + 64'h6D0,  4'hF, 32'h0,        32'h34400000, 4'd6},  // R6
        '{1'b0, 1'b0, B + 64'h6D4,  4'hF, 32'h0,        32'h12,       4'd6},  // R6
        '{1'b0, 1'b0, B + 64'h86D0, 4'hF, 32'h0,        32'h0,        4'd6},  // R6
        '{1'b1, 1'b1, 64'h14,       4'h2, 32'h00005600, 32'h0,        4'd8},  // R8
        '{1'b1, 1'b0, 64'h14,       4'hF, 32'h0,        32'h5612,     4'd8},  // R8
        '{1'b0, 1'b0, B2 + 64'h6D4, 4'hF, 32'h0,        32'h5612,     4'd8},  // R8
        '{1'b0, 1'b0, B + 64'h6D4,  4'hF, 32'h0,        32'h0,        4'd3},  // R3 moved
        '{1'b1, 1'b1, 64'h14,       4'h2, 32'h0,        32'h0,        4'd8},  // R8
        '{1'b0, 1'b1, B + 64'h40,   4'h9, 32'h11223344, 32'h0,        4'd8},  // R8
        '{1'b0, 1'b0, B + 64'h40,   4'hF, 32'h0,        32'h11A00044, 4'd8},  // R8
        '{1'b0, 1'b1, B + 64'h6D0,  4'hF, 32'h55550000, 32'h0,        4'd7},  // R7
        '{1'b0, 1'b0, B + 64'h6D0,  4'hF, 32'h0,        32'h55550000, 4'd7},  // R7
        '{1'b1, 1'b0, 64'h10,       4'hF, 32'h0,        32'h34400000, 4'd7},  // R7
        '{1'b0, 1'b0, B + 64'h40,   4'hF, 32'h0,        32'h11A00044, 4'd7}   // R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  upstream_port = 4'd2;
    logic        req_valid = 1'b0;
    logic        req_cfg = 1'b0;
    logic        req_write = 1'b0;
    logic [63:0] addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mmcfg_window_decoder u_mmcfg_window_decoder (
        .clk          (clk),
        .rst          (rst),
        .upstream_port(upstream_port),
        .req_valid    (req_valid),
        .req_cfg      (req_cfg),
        .req_write    (req_write),
        .req_addr     (addr[63:2]),
        .req_be       (req_be),
        .req_wdata    (req_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic c, input logic w, input logic [63:0] a,
                           input logic [3:0] be, input logic [31:0] d,
                           output logic v, output logic [31:0] r);
        @(negedge clk);
        req_valid = 1'b1; req_cfg = c; req_write = w;
        addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        v = rsp_valid; r = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; req_cfg = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic        v;
        logic [31:0] r;

        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_req(VECS[i].cfg, VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata, v, r);
            if (!VECS[i].wr) begin
                check($sformatf("R%0d vec %0d data", VECS[i].req, i), r, VECS[i].exp);
                check($sformatf("R9 vec %0d valid", i), {31'b0, v}, 32'h1);
            end else begin
                check($sformatf("R9 vec %0d no rsp on write", i), {31'b0, v}, 32'h0);
            end
        end

        // R9: single-cycle strobe
        run_req(1'b1, 1'b0, 64'h4, 4'hF, 32'h0, v, r);
        @(negedge clk);
        check("R9 strobe drops after one cycle", {31'b0, rsp_valid}, 32'h0);
        check("R9 idle data zero", rsp_rdata, 32'h0);

        // R6: upstream in second station copies into port 8 only
        upstream_port = 4'd10;
        run_req(1'b1, 1'b1, 64'h10, 4'hF, 32'h34400000, v, r);
        run_req(1'b1, 1'b1, 64'h14, 4'hF, 32'h12, v, r);
        run_req(1'b0, 1'b0, B + 64'h86D0, 4'hF, 32'h0, v, r);
        check("R6 port8 shadow low", r, 32'h34400000);
        run_req(1'b0, 1'b0, B + 64'h86D4, 4'hF, 32'h0, v, r);
        check("R6 port8 shadow high", r, 32'h12);
        run_req(1'b0, 1'b0, B + 64'h6D0, 4'hF, 32'h0, v, r);
        check("R6 port0 shadow untouched", r, 32'h55550000);

        // R1: reset clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 rsp_valid held low", {31'b0, rsp_valid}, 32'h0);
        rst = 1'b0;
        upstream_port = 4'd0;
        run_req(1'b1, 1'b0, 64'h10, 4'hF, 32'h0, v, r);
        check("R1 base cleared", r, 32'h0);
        run_req(1'b1, 1'b0, 64'h6D0, 4'hF, 32'h0, v, r);
        check("R1 shadow cleared", r, 32'h0);
        run_req(1'b1, 1'b0, 64'h40, 4'hF, 32'h0, v, r);
        check("R1 scratch cleared", r, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule